// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a narrow window (3-bit address, 16-bit data) reach a wide internal register space with 12-bit addresses and 32-bit registers. The host stages a 32-bit value in two 16-bit holding locations. It then writes a target address to a command location. The bridge produces its own delayed strobe and copies the staged value into the addressed internal register.

A second command location starts an indirect read. The result lands in a separate read-holding register, and the host fetches it through the same two 16-bit locations. A busy indication covers the fixed command latency.

The status location returns a revision code and four sticky saturation flags, one per channel. Each flag is fed by the OR of several per-channel saturation inputs. An indirect write to internal register 0x01F clears the flags. The internal register file is modelled as a small resettable array.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, busy_o is 0, reads of direct addresses 0, 1 and 3 return 0, and address 2 returns {REV_CODE, 8'h00}.
- R2: While idle, a write to direct address 0 stages bits 15:0 and a write to address 1 stages bits 31:16 of the 32-bit write-holding value. Neither write changes what addresses 0 and 1 read back.
- R3: While idle, a write to direct address 2 (indirect write) or 3 (indirect read) sets busy_o from the next cycle for exactly 4 cycles.
- R4: While busy_o is 1, writes to direct addresses 0, 1, 2 and 3 are ignored.
- R5: When an indirect write completes, the staged 32-bit value is stored at the target, and direct addresses 0 and 1 read back its low and high halves.
- R6: When an indirect read completes, direct addresses 0 and 1 return the target register's low and high halves. A read leaves the write-holding value unchanged.
- R7: Direct address 2 reads {REV_CODE, 1'b0, flag3, 1'b0, flag2, 1'b0, flag1, 1'b0, flag0}. REV_CODE defaults to 8'h01 (production; 8'h00 means prototype).
- R8: Flag c is set at any clock edge where any bit of sat_i[c*4 +: 4] is 1, and it stays set.
- R9: Completion of an indirect write to target 0x01F clears every flag, except that a channel whose saturation input is high at that same edge keeps its flag set.
- R10: Indirect writes to targets at or above DEPTH (64) are dropped, and indirect reads from them return 0.
- R11: Direct address 3 reads the last accepted target address, zero-extended. Direct addresses 4 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe for the direct window |
| addr_i | input | 3 | Direct window address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Direct window read data (combinational on addr_i) |
| busy_o | output | 1 | Indirect command in progress |
| sat_i | input | 16 | Per-channel saturation inputs, 4 per channel |

## Verification
The clear strobe for the saturation flags can land in the same cycle as a new saturation event on one channel. The bench starts an indirect write to 0x01F and raises one channel's saturation input exactly on the completion edge, four cycles after the command. It expects that channel's flag to survive while the other flags clear. A second overlap, a holding-register or command write arriving during busy, is provoked one cycle after a command. It is judged by reading back the address latch and the data that was stored.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_WR, OP_RD} op_e;
  localparam logic [2:0] DA_LO   = 3'd0;
  localparam logic [2:0] DA_HI   = 3'd1;
  localparam logic [2:0] DA_WCMD = 3'd2;
  localparam logic [2:0] DA_RCMD = 3'd3;
endpackage

// File: rtl/ind_seq.sv
module ind_seq
  import ind_bridge_pkg::*;
#(
  parameter int LAT = 4,
  parameter int AW  = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_wr_i,
  input  logic          start_rd_i,
  input  logic [AW-1:0] tgt_i,
  output logic          busy_o,
  output logic          done_wr_o,
  output logic          done_rd_o,
  output logic [AW-1:0] tgt_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  op_e           op_q;
  logic [AW-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      op_q  <= OP_NONE;
      tgt_q <= '0;
    end else if (cnt_q == '0 && (start_wr_i || start_rd_i)) begin
      cnt_q <= CW'(LAT);
      op_q  <= start_wr_i ? OP_WR : OP_RD;
      tgt_q <= tgt_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o    = (cnt_q != '0);
  assign done_wr_o = (cnt_q == CW'(1)) && (op_q == OP_WR);
  assign done_rd_o = (cnt_q == CW'(1)) && (op_q == OP_RD);
  assign tgt_o     = tgt_q;

  assert_busy_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((start_wr_i || start_rd_i) && !busy_o) |=> busy_o);
  assert_done_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_wr_o || done_rd_o) |=> !busy_o);
  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LAT));
endmodule

// File: rtl/ind_hold_regs.sv
module ind_hold_regs #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic [DW/2-1:0] data_i,
  input  logic          done_wr_i,
  input  logic          done_rd_i,
  input  logic [DW-1:0] arr_rdata_i,
  output logic [DW-1:0] wr_hold_o,
  output logic [DW-1:0] rd_hold_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] wr_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
    end else begin
      if (ld_lo_i) wr_q[HW-1:0]  <= data_i;
      if (ld_hi_i) wr_q[DW-1:HW] <= data_i;
    end
  end

  // separate read holding keeps staged write data intact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd_q <= '0;
    else if (done_rd_i) rd_q <= arr_rdata_i;
    else if (done_wr_i) rd_q <= wr_q;
  end

  assign wr_hold_o = wr_q;
  assign rd_hold_o = rd_q;

  assert_rdhold_after_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_wr_i |=> (rd_hold_o == $past(wr_hold_o)));
  assert_wrhold_kept_on_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_rd_i && !ld_lo_i && !ld_hi_i) |=> $stable(wr_hold_o));
endmodule

// File: rtl/ind_reg_array.sv
module ind_reg_array #(
  parameter int DEPTH = 64,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic          in_range;
  logic [IW-1:0] idx;

  assign in_range = (32'(addr_i) < DEPTH);
  assign idx      = addr_i[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && in_range) begin
      mem_q[idx] <= wdata_i;
    end
  end

  assign rdata_o = in_range ? mem_q[idx] : '0;

  assert_oob_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> (rdata_o == '0));
endmodule

// File: rtl/ind_sat_status.sv
module ind_sat_status #(
  parameter int NCH  = 4,
  parameter int NSRC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH*NSRC-1:0] sat_i,
  input  logic              clr_i,
  output logic [NCH-1:0]    flag_o
);
  logic [NCH-1:0] hit, flag_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit[c] = |sat_i[c*NSRC +: NSRC];

    // new event wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[c] <= 1'b0;
      else         flag_q[c] <= (flag_q[c] & ~clr_i) | hit[c];
    end

    assert_sat_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[c] |=> flag_o[c]);
    assert_sat_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !hit[c]) |=> !flag_o[c]);
    assert_sat_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[c] && !clr_i) |=> flag_o[c]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_bridge_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter int          NSRC     = 4,
  parameter int          AW       = 12,
  parameter int          DW       = 32,
  parameter int          DEPTH    = 64,
  parameter int          LAT      = 4,
  parameter logic [7:0]  REV_CODE = 8'h01,
  parameter logic [11:0] CLR_ADDR = 12'h01F
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2:0]          addr_i,
  input  logic [DW/2-1:0]     wdata_i,
  output logic [DW/2-1:0]     rdata_o,
  output logic                busy_o,
  input  logic [NCH*NSRC-1:0] sat_i
);
  localparam int HW = DW / 2;

  logic          busy, done_wr, done_rd, start_wr, start_rd, ld_lo, ld_hi, clr;
  logic [AW-1:0] tgt;
  logic [DW-1:0] wr_hold, rd_hold, arr_rdata;
  logic [NCH-1:0] flags;
  logic [7:0]    stat_lo;

  assign ld_lo    = wr_en_i && !busy && (addr_i == DA_LO);
  assign ld_hi    = wr_en_i && !busy && (addr_i == DA_HI);
  assign start_wr = wr_en_i && !busy && (addr_i == DA_WCMD);
  assign start_rd = wr_en_i && !busy && (addr_i == DA_RCMD);

  ind_seq #(.LAT(LAT), .AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .start_wr_i(start_wr), .start_rd_i(start_rd),
    .tgt_i(wdata_i[AW-1:0]),
    .busy_o(busy), .done_wr_o(done_wr), .done_rd_o(done_rd), .tgt_o(tgt)
  );

  ind_hold_regs #(.DW(DW)) u_hold (
    .clk_i, .rst_ni,
    .ld_lo_i(ld_lo), .ld_hi_i(ld_hi), .data_i(wdata_i),
    .done_wr_i(done_wr), .done_rd_i(done_rd), .arr_rdata_i(arr_rdata),
    .wr_hold_o(wr_hold), .rd_hold_o(rd_hold)
  );

  ind_reg_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arr (
    .clk_i, .rst_ni,
    .we_i(done_wr), .addr_i(tgt), .wdata_i(wr_hold), .rdata_o(arr_rdata)
  );

  assign clr = done_wr && (tgt == CLR_ADDR);

  ind_sat_status #(.NCH(NCH), .NSRC(NSRC)) u_sat (
    .clk_i, .rst_ni, .sat_i, .clr_i(clr), .flag_o(flags)
  );

  always_comb begin
    stat_lo = '0;
    for (int c = 0; c < NCH; c++) stat_lo[2*c] = flags[c];
  end

  always_comb begin
    unique case (addr_i)
      DA_LO:   rdata_o = rd_hold[HW-1:0];
      DA_HI:   rdata_o = rd_hold[DW-1:HW];
      DA_WCMD: rdata_o = {REV_CODE, stat_lo};
      DA_RCMD: rdata_o = HW'(tgt);
      default: rdata_o = '0;
    endcase
  end

  assign busy_o = busy;

  assert_hold_ignore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy && (addr_i == DA_LO || addr_i == DA_HI)) |=> $stable(wr_hold));
  assert_cmd_ignore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_wr && !done_rd) |=> $stable(tgt));
  assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |=> busy);
endmodule

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic        busy_o;
  logic [15:0] sat_i = '0;

  int checks = 0, errors = 0;

  ind_reg_bridge u_ind_reg_bridge (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .busy_o, .sat_i
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // {target[11:0], data[31:0]}
  localparam logic [43:0] VEC [5] = '{
    {12'h000, 32'h1234_5678},
    {12'h03F, 32'hFFFF_0000},
    {12'h015, 32'hA5A5_5A5A},
    {12'h040, 32'hDEAD_BEEF},
    {12'h100, 32'h0F0F_F0F0}
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic hwr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    cyc(1);
    wr_en_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    addr_i = a; #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic ind_write(input logic [11:0] t, input logic [31:0] d);
    hwr(3'd0, d[15:0]); hwr(3'd1, d[31:16]); hwr(3'd2, {4'h0, t});
    cyc(4);
  endtask

  task automatic ind_read(input logic [11:0] t);
    hwr(3'd3, {4'h0, t});
    cyc(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1 busy", {15'd0, busy_o}, 16'h0000);
    rd_chk("R1 lo", 3'd0, 16'h0000);
    rd_chk("R1 hi", 3'd1, 16'h0000);
    rd_chk("R1 tgt", 3'd3, 16'h0000);
    rd_chk("R1 R7 status", 3'd2, 16'h0100);
    rst_ni = 1'b1;
    cyc(1);

    // R3 busy window
    hwr(3'd0, 16'h1111); hwr(3'd1, 16'h2222);
    // R2 staging does not alter readback
    rd_chk("R2 lo unchanged", 3'd0, 16'h0000);
    hwr(3'd2, 16'h0005);
    chk("R3 busy c1", {15'd0, busy_o}, 16'h0001);
    cyc(3);
    chk("R3 busy c4", {15'd0, busy_o}, 16'h0001);
    cyc(1);
    chk("R3 busy end", {15'd0, busy_o}, 16'h0000);
    rd_chk("R5 lo", 3'd0, 16'h1111);
    rd_chk("R5 hi", 3'd1, 16'h2222);
    rd_chk("R11 tgt", 3'd3, 16'h0005);

    // vector table: write then read back
    for (int i = 0; i < 5; i++) begin
      logic [11:0] t;
      logic [31:0] d, e;
      t = VEC[i][43:32]; d = VEC[i][31:0];
      e = (t < 12'd64) ? d : 32'h0;
      ind_write(t, d);
      rd_chk("R5 vec lo", 3'd0, d[15:0]);
      rd_chk("R5 vec hi", 3'd1, d[31:16]);
      ind_read(12'h005);
      ind_read(t);
      rd_chk("R6 R10 vec lo", 3'd0, e[15:0]);
      rd_chk("R6 R10 vec hi", 3'd1, e[31:16]);
    end

    // R6 read leaves staged data intact
    hwr(3'd0, 16'hCAFE); hwr(3'd1, 16'hBABE);
    ind_read(12'h015);
    rd_chk("R6 read lo", 3'd0, 16'h5A5A);
    hwr(3'd2, 16'h0020); cyc(4);
    ind_read(12'h020);
    rd_chk("R6 staged lo", 3'd0, 16'hCAFE);
    rd_chk("R6 staged hi", 3'd1, 16'hBABE);

    // R4 writes during busy ignored
    hwr(3'd0, 16'h0101); hwr(3'd1, 16'h0202);
    hwr(3'd2, 16'h0030);
    hwr(3'd0, 16'hDEAD);
    hwr(3'd3, 16'h0031);
    hwr(3'd2, 16'h0032);
    cyc(2);
    rd_chk("R4 tgt kept", 3'd3, 16'h0030);
    ind_read(12'h030);
    rd_chk("R4 lo kept", 3'd0, 16'h0101);
    ind_read(12'h032);
    rd_chk("R4 no second write", 3'd0, 16'h0000);

    // R11 addresses 4..7
    hwr(3'd5, 16'hFFFF);
    rd_chk("R11 a5", 3'd5, 16'h0000);
    rd_chk("R11 a7", 3'd7, 16'h0000);
    chk("R11 no busy", {15'd0, busy_o}, 16'h0000);
    rd_chk("R11 tgt after a5", 3'd3, 16'h0032);

    // R8 sticky flags, R7 layout
    sat_i = 16'h8011; cyc(1); sat_i = 16'h0000; cyc(3);
    rd_chk("R8 R7 flags", 3'd2, 16'h0145);
    sat_i = 16'h0200; cyc(1); sat_i = '0;
    rd_chk("R8 ch2", 3'd2, 16'h0155);

    // R9 clear, channel 1 event on clear edge wins
    hwr(3'd2, 16'h001F);
    cyc(3);
    rd_chk("R9 before clear", 3'd2, 16'h0155);
    sat_i = 16'h0020;
    cyc(1);
    sat_i = 16'h0000;
    rd_chk("R9 clear priority", 3'd2, 16'h0104);
    cyc(2);
    rd_chk("R9 stays", 3'd2, 16'h0104);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule